// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is a per-core event counting unit. It holds one 32-bit cycle counter and a parameterised number (1 to 31) of 32-bit event counters. Each event counter watches one line of a 128-wide event input bus, chosen by its own 7-bit type register. On every clock edge where that line is high and counting is enabled, the counter advances by one. The cycle counter advances on every clock. It can instead advance once every 64 clocks, and it can be held while an external debug-prohibit signal is high.

Software reaches the unit through a flat register port. Writes take effect at the clock edge. Reads are combinational from the address. Event counters are reached indirectly: a select register names one counter, and the data and type registers then act on that counter. Counter enables and overflow-interrupt enables each have a set register and a clear register, so single bits can change without a read-modify-write. Overflow flags are cleared by writing ones. A single interrupt output is high while any counter has both its flag and its interrupt enable set.

All per-counter masks share one layout. Bit n belongs to event counter n, and bit 31 belongs to the cycle counter.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every counter, mask and flag reads 0. The control register (address 0) reads NUM_CNT in bits [15:11] and 0 in all other bits. The self-clearing bits 1 and 2 of the control register always read 0.
- R2: Writing ones to address 1 sets counter enable bits, and writing ones to address 2 clears them; zero bits leave a bit unchanged. Both addresses read the enable mask. Bit n is event counter n and bit 31 is the cycle counter. Bits of unimplemented counters read 0.
- R3: A counter advances only while control bit 0 (global enable) and its own enable bit are both 1.
- R4: An event counter advances by one on each enabled clock edge where evt_in[type] is 1. Here type is its 7-bit type register, written through address 9.
- R5: The select register (address 6, 5 bits) picks the event counter reached by the data register (address 8) and the type register (address 9). A select value of NUM_CNT or above makes both read 0 and ignores writes to them.
- R6: Writing control bit 1 as 1 zeroes all event counters. Writing control bit 2 as 1 zeroes the cycle counter and its prescaler.
- R7: With control bit 3 set, the cycle counter advances once per 64 enabled clocks: 63 clocks give 0, 64 give 1 and 200 give 3. Event counters are not divided.
- R8: With control bit 5 set and dbg_prohibit high, the cycle counter holds while event counters keep counting. With bit 5 clear, dbg_prohibit has no effect.
- R9: Counters wrap from 0xFFFFFFFF to 0, and the counter's flag in the overflow register (address 5) is set at that same edge. Loading a counter through a write is not a wrap.
- R10: Writing ones to address 5 clears those flags; zero bits have no effect. A wrap at the same edge as a clear of that flag leaves the flag set.
- R11: Addresses 3 and 4 set and clear interrupt-enable bits with the same write-one rules; both addresses read the mask. irq is high exactly while some counter has both its flag and its interrupt enable set.
- R12: The cycle counter (address 7) and the selected event counter (address 8) can be written with any value, and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_in | input | 128 | Event lines, one bit per event type |
| dbg_prohibit | input | 1 | Debug-prohibited state, holds the cycle counter when control bit 5 is set |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Two functions can fall in the same cycle: a counter wrapping, which sets its overflow flag, and a software write-one-to-clear of that same flag. The bench loads an event counter with 0xFFFFFFFF and turns on the global enable. It places the clear write on the next edge, the one where the counter wraps, and then requires the flag to read 1 and the counter to continue from 0. A 128-step sweep of the event type, with a one-hot event bus, checks that only the selected line is counted. Separate runs of 63, 64 and 200 clocks check the prescaler boundaries.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int CNT_W   = 32;
    localparam int MASK_W  = 32;
    localparam int SEL_W   = 5;
    localparam int TYPE_W  = 7;
    localparam int NUM_EVT = 1 << TYPE_W;
    localparam int PRESC_W = 6;
    localparam int ADDR_W  = 4;
    localparam int CYC_BIT = 31;

    // control register bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_CLR_EV  = 1;
    localparam int CB_CLR_CYC = 2;
    localparam int CB_DIV     = 3;
    localparam int CB_EXPORT  = 4;
    localparam int CB_DBG_OFF = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 4'd0,
        RA_EN_SET = 4'd1,
        RA_EN_CLR = 4'd2,
        RA_IE_SET = 4'd3,
        RA_IE_CLR = 4'd4,
        RA_OVF    = 4'd5,
        RA_SEL    = 4'd6,
        RA_CYC    = 4'd7,
        RA_EVDATA = 4'd8,
        RA_EVTYPE = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/pmu_setclr_mask.sv
module pmu_setclr_mask #(
    parameter int          W    = 32,
    parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    assign set_bits = set_we ? wdata : '0;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            mask <= (mask | set_bits) & ~clr_bits & IMPL[W-1:0];
        end
    end
endmodule

// File: rtl/pmu_ovf_flags.sv
module pmu_ovf_flags #(
    parameter int          W    = 32,
    parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wrap_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    // a new wrap takes priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= ((flags & ~clr_bits) | wrap_vec) & IMPL[W-1:0];
        end
    end
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
    parameter int CW = 32,
    parameter int TW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_cnt,
    input  logic              wr_type,
    input  logic [CW-1:0]     wr_data,
    input  logic              count_on,
    input  logic [(1<<TW)-1:0] evt_vec,
    output logic [CW-1:0]     count,
    output logic [TW-1:0]     evt_type,
    output logic              wrap
);
    logic hit;

    assign hit  = count_on & evt_vec[evt_type];
    assign wrap = hit & (&count) & ~clr & ~wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            evt_type <= '0;
        end else begin
            if (clr) begin
                count <= '0;
            end else if (wr_cnt) begin
                count <= wr_data;
            end else if (hit) begin
                count <= count + 1'b1;
            end
            if (wr_type) begin
                evt_type <= wr_data[TW-1:0];
            end
        end
    end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
    parameter int CW = 32,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [CW-1:0] wr_data,
    input  logic          run,
    input  logic          div,
    output logic [CW-1:0] count,
    output logic          wrap
);
    logic [PW-1:0] presc;
    logic          step;

    // with division on, step only when the prescaler is at its last value
    assign step = run & (~div | (&presc));
    assign wrap = step & (&count) & ~clr & ~wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            presc <= '0;
        end else if (clr) begin
            count <= '0;
            presc <= '0;
        end else begin
            if (wr) begin
                count <= wr_data;
            end else if (step) begin
                count <= count + 1'b1;
            end
            if (run && div) begin
                presc <= presc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [MASK_W-1:0]  reg_wdata,
    output logic [MASK_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               dbg_prohibit,
    output logic               irq
);
    localparam logic [MASK_W-1:0] IMPL_MASK =
        (MASK_W'(1) << CYC_BIT) | ((MASK_W'(1) << NUM_CNT) - MASK_W'(1));

    // write decode
    logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
    logic wr_ovf, wr_sel, wr_cyc, wr_evdata, wr_evtype;
    logic clr_ev, clr_cyc;

    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign wr_en_set = reg_wr && (reg_addr == RA_EN_SET);
    assign wr_en_clr = reg_wr && (reg_addr == RA_EN_CLR);
    assign wr_ie_set = reg_wr && (reg_addr == RA_IE_SET);
    assign wr_ie_clr = reg_wr && (reg_addr == RA_IE_CLR);
    assign wr_ovf    = reg_wr && (reg_addr == RA_OVF);
    assign wr_sel    = reg_wr && (reg_addr == RA_SEL);
    assign wr_cyc    = reg_wr && (reg_addr == RA_CYC);
    assign wr_evdata = reg_wr && (reg_addr == RA_EVDATA);
    assign wr_evtype = reg_wr && (reg_addr == RA_EVTYPE);
    assign clr_ev    = wr_ctrl && reg_wdata[CB_CLR_EV];
    assign clr_cyc   = wr_ctrl && reg_wdata[CB_CLR_CYC];

    // stored control bits and select register
    logic             glob_en, div64, export_en, dbg_off;
    logic [SEL_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en   <= 1'b0;
            div64     <= 1'b0;
            export_en <= 1'b0;
            dbg_off   <= 1'b0;
            sel       <= '0;
        end else begin
            if (wr_ctrl) begin
                glob_en   <= reg_wdata[CB_RUN];
                div64     <= reg_wdata[CB_DIV];
                export_en <= reg_wdata[CB_EXPORT];
                dbg_off   <= reg_wdata[CB_DBG_OFF];
            end
            if (wr_sel) begin
                sel <= reg_wdata[SEL_W-1:0];
            end
        end
    end

    // per-counter masks
    logic [MASK_W-1:0] en_mask, ien_mask, ovf_flags, wrap_vec;

    pmu_setclr_mask #(.W(MASK_W), .IMPL(IMPL_MASK)) u_en_mask (
        .clk(clk), .rst_n(rst_n), .set_we(wr_en_set), .clr_we(wr_en_clr),
        .wdata(reg_wdata), .mask(en_mask)
    );

    pmu_setclr_mask #(.W(MASK_W), .IMPL(IMPL_MASK)) u_ien_mask (
        .clk(clk), .rst_n(rst_n), .set_we(wr_ie_set), .clr_we(wr_ie_clr),
        .wdata(reg_wdata), .mask(ien_mask)
    );

    pmu_ovf_flags #(.W(MASK_W), .IMPL(IMPL_MASK)) u_ovf (
        .clk(clk), .rst_n(rst_n), .clr_we(wr_ovf), .wdata(reg_wdata),
        .wrap_vec(wrap_vec), .flags(ovf_flags)
    );

    // cycle counter
    logic [CNT_W-1:0] cyc_count;
    logic             cyc_wrap;
    logic             cyc_run;

    assign cyc_run = glob_en & en_mask[CYC_BIT] & ~(dbg_off & dbg_prohibit);

    pmu_cycle_counter #(.CW(CNT_W), .PW(PRESC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .wr(wr_cyc),
        .wr_data(reg_wdata), .run(cyc_run), .div(div64),
        .count(cyc_count), .wrap(cyc_wrap)
    );

    // event counters
    logic [CNT_W-1:0]  ev_count [NUM_CNT];
    logic [TYPE_W-1:0] ev_type  [NUM_CNT];
    logic [NUM_CNT-1:0] ev_wrap;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_ev
        logic hit_sel;
        assign hit_sel = (sel == SEL_W'(g));

        pmu_event_counter #(.CW(CNT_W), .TW(TYPE_W)) u_ev (
            .clk(clk), .rst_n(rst_n), .clr(clr_ev),
            .wr_cnt(wr_evdata && hit_sel), .wr_type(wr_evtype && hit_sel),
            .wr_data(reg_wdata), .count_on(glob_en & en_mask[g]),
            .evt_vec(evt_in), .count(ev_count[g]), .evt_type(ev_type[g]),
            .wrap(ev_wrap[g])
        );
    end

    always_comb begin
        wrap_vec = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            wrap_vec[i] = ev_wrap[i];
        end
        wrap_vec[CYC_BIT] = cyc_wrap;
    end

    // selected counter view; out-of-range select reads 0
    logic [CNT_W-1:0]  sel_count;
    logic [TYPE_W-1:0] sel_type;

    always_comb begin
        sel_count = '0;
        sel_type  = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel == SEL_W'(i)) begin
                sel_count = ev_count[i];
                sel_type  = ev_type[i];
            end
        end
    end

    // read mux
    logic [MASK_W-1:0] ctrl_rd;

    assign ctrl_rd = {16'b0, 5'(NUM_CNT), 5'b0, dbg_off, export_en, div64, 2'b00, glob_en};

    always_comb begin
        case (reg_addr)
            RA_CTRL:              reg_rdata = ctrl_rd;
            RA_EN_SET, RA_EN_CLR: reg_rdata = en_mask;
            RA_IE_SET, RA_IE_CLR: reg_rdata = ien_mask;
            RA_OVF:               reg_rdata = ovf_flags;
            RA_SEL:               reg_rdata = MASK_W'(sel);
            RA_CYC:               reg_rdata = cyc_count;
            RA_EVDATA:            reg_rdata = sel_count;
            RA_EVTYPE:            reg_rdata = MASK_W'(sel_type);
            default:              reg_rdata = '0;
        endcase
    end

    assign irq = |(ovf_flags & ien_mask);
endmodule

// File: rtl/pmu_counter_unit_chk.sv
module pmu_counter_unit_chk #(
    parameter int NUM_CNT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_addr,
    input logic        reg_wr,
    input logic        wd_bit0,
    input logic        wd_bit2,
    input logic        irq,
    input logic [31:0] en_mask,
    input logic [31:0] ien_mask,
    input logic [31:0] ovf_flags,
    input logic        glob_en,
    input logic [31:0] cyc_count,
    input logic        ev0_wrap
);
    localparam logic [31:0] IMPL = (32'd1 << 31) | ((32'd1 << NUM_CNT) - 32'd1);

    logic cyc_touched;
    assign cyc_touched = reg_wr && ((reg_addr == 4'd7) || ((reg_addr == 4'd0) && wd_bit2));

    // R2: bits of unimplemented counters stay zero
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_mask & ~IMPL) == 32'd0) && ((ovf_flags & ~IMPL) == 32'd0));

    // R3: cycle counter holds while globally disabled and untouched
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !cyc_touched) |=> $stable(cyc_count));

    // R9: a wrap of event counter 0 sets its flag
    p_wrap_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev0_wrap |=> ovf_flags[0]);

    // R10: a clear without a coincident wrap takes the flag down
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 4'd5) && wd_bit0 && !ev0_wrap) |=> !ovf_flags[0]);

    // R11: no interrupt without an enable, and none without a flag
    p_irq_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_mask == 32'd0) |-> !irq);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flags != 32'd0));
endmodule

bind pmu_counter_unit pmu_counter_unit_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .wd_bit0(reg_wdata[0]), .wd_bit2(reg_wdata[2]), .irq(irq),
    .en_mask(en_mask), .ien_mask(ien_mask), .ovf_flags(ovf_flags),
    .glob_en(glob_en), .cyc_count(cyc_count), .ev0_wrap(ev_wrap[0])
);

// File: tb/test_pmu_counter_unit.sv
`timescale 1ns/1ps
module test_pmu_counter_unit;
    localparam int N = 4;
    localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_IES = 4'd3,
                           A_IEC = 4'd4, A_OVF = 4'd5, A_SEL = 4'd6, A_CYC = 4'd7,
                           A_DAT = 4'd8, A_TYP = 4'd9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [127:0] evt_in = '0;
    logic         dbg_prohibit = 1'b0;
    logic         irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] rv;
    logic [31:0] saved;

    always #10 clk = ~clk;

    pmu_counter_unit #(.NUM_CNT(N)) i_pmu_counter_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .dbg_prohibit(dbg_prohibit), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #2 d = reg_rdata;
    endtask

    task automatic rd_ev(input logic [4:0] s, output logic [31:0] d);
        wr(A_SEL, 32'(s));
        rd(A_DAT, d);
    endtask

    // counts exactly m enabled edges; base keeps the other control bits
    task automatic run(input int m, input logic [31:0] base);
        wr(A_CTRL, base | 32'h1);
        repeat (m - 1) @(posedge clk);
        wr(A_CTRL, base);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0000_2000);
        rd(A_ENS, rv);  check("R1 enable", rv, 32'h0);
        rd(A_OVF, rv);  check("R1 flags", rv, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 set/clear enables
        wr(A_ENS, 32'hFFFF_FFFF); rd(A_ENS, rv); check("R2 set all", rv, 32'h8000_000F);
        wr(A_ENC, 32'h2);         rd(A_ENC, rv); check("R2 clear bit1", rv, 32'h8000_000D);
        wr(A_ENS, 32'h0); wr(A_ENC, 32'h0);
        rd(A_ENS, rv); check("R2 zero writes", rv, 32'h8000_000D);
        wr(A_ENS, 32'h2); rd(A_ENS, rv); check("R2 set bit1", rv, 32'h8000_000F);

        // R1 reset pulse bits read 0
        wr(A_CTRL, 32'h6); rd(A_CTRL, rv); check("R1 pulses read 0", rv, 32'h0000_2000);

        // R4 sweep over all event types
        for (int t = 0; t < 128; t++) begin
            wr(A_SEL, 0); wr(A_TYP, 32'(t));
            wr(A_SEL, 1); wr(A_TYP, 32'((t + 1) % 128));
            evt_in = 128'd1 << t;
            wr(A_CTRL, 32'h6);
            run(5, 32'h0);
            rd_ev(0, rv); check("R4 selected line", rv, 32'd5);
            rd_ev(1, rv); check("R4 other line", rv, 32'd0);
        end
        wr(A_SEL, 0); rd(A_TYP, rv); check("R4 type readback", rv, 32'd127);

        // R3 own enable and global enable
        evt_in = '1;
        wr(A_SEL, 2); wr(A_TYP, 32'd127);
        wr(A_ENC, 32'h4);
        wr(A_CTRL, 32'h6);
        run(7, 32'h0);
        rd_ev(0, rv); check("R3 enabled counter", rv, 32'd7);
        rd_ev(2, rv); check("R3 disabled counter", rv, 32'd0);
        rd(A_CYC, rv); check("R3 cycle count", rv, 32'd7);
        repeat (10) @(posedge clk);
        rd_ev(0, rv); check("R3 global off holds", rv, 32'd7);
        wr(A_ENS, 32'h4);

        // R7 divide by 64
        wr(A_CTRL, 32'hE); run(63, 32'h8);
        rd(A_CYC, rv); check("R7 63 clocks", rv, 32'd0);
        wr(A_CTRL, 32'hE); run(64, 32'h8);
        rd(A_CYC, rv); check("R7 64 clocks", rv, 32'd1);
        wr(A_CTRL, 32'hE); run(200, 32'h8);
        rd(A_CYC, rv); check("R7 200 clocks", rv, 32'd3);
        rd_ev(0, rv); check("R7 events undivided", rv, 32'd200);

        // R8 debug prohibit
        wr(A_CTRL, 32'h26); dbg_prohibit = 1'b1; run(10, 32'h20);
        rd(A_CYC, rv); check("R8 cycle held", rv, 32'd0);
        rd_ev(0, rv); check("R8 events continue", rv, 32'd10);
        dbg_prohibit = 1'b0; wr(A_CTRL, 32'h26); run(10, 32'h20);
        rd(A_CYC, rv); check("R8 not prohibited", rv, 32'd10);
        wr(A_CTRL, 32'h06); dbg_prohibit = 1'b1; run(10, 32'h0);
        rd(A_CYC, rv); check("R8 bit5 clear", rv, 32'd10);
        dbg_prohibit = 1'b0;

        // R12 direct loads, R9 wrap
        wr(A_OVF, 32'hFFFF_FFFF);
        wr(A_SEL, 0); wr(A_DAT, 32'hFFFF_FFFE);
        rd(A_DAT, rv); check("R12 event load", rv, 32'hFFFF_FFFE);
        wr(A_CYC, 32'h1234_5678);
        rd(A_CYC, rv); check("R12 cycle load", rv, 32'h1234_5678);
        rd(A_OVF, rv); check("R9 load is no wrap", rv, 32'h0);
        run(3, 32'h0);
        rd(A_DAT, rv); check("R9 wrapped value", rv, 32'd1);
        rd(A_OVF, rv); check("R9 event flag", rv, 32'h1);
        check("R11 irq masked", 32'(irq), 32'h0);

        // R11 interrupt enables
        wr(A_IES, 32'h1); rd(A_IES, rv); check("R11 ie set", rv, 32'h1);
        check("R11 irq on", 32'(irq), 32'h1);
        wr(A_IES, 32'h8000_0000); rd(A_IEC, rv); check("R11 ie set 31", rv, 32'h8000_0001);
        wr(A_IEC, 32'h1); rd(A_IES, rv); check("R11 ie clear", rv, 32'h8000_0000);
        check("R11 irq off", 32'(irq), 32'h0);
        wr(A_IES, 32'h1); rd(A_OVF, rv); check("R11 irq back on", 32'(irq), 32'h1);

        // R10 write-one-to-clear
        wr(A_OVF, 32'h0); rd(A_OVF, rv); check("R10 zero write", rv, 32'h1);
        wr(A_OVF, 32'h1); rd(A_OVF, rv); check("R10 clear", rv, 32'h0);
        check("R10 irq after clear", 32'(irq), 32'h0);

        // R9 cycle counter wrap on bit 31
        wr(A_CYC, 32'hFFFF_FFFF); run(1, 32'h0);
        rd(A_CYC, rv); check("R9 cycle wrap value", rv, 32'h0);
        rd(A_OVF, rv); check("R9 cycle flag", rv, 32'h8000_0000);
        check("R11 irq from cycle", 32'(irq), 32'h1);
        wr(A_OVF, 32'h8000_0000);

        // R10 wrap and clear on the same edge
        wr(A_SEL, 0); wr(A_DAT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        wr(A_OVF, 32'h1);
        wr(A_CTRL, 32'h0);
        rd(A_OVF, rv); check("R10 wrap beats clear", rv, 32'h1);
        rd(A_DAT, rv); check("R10 count after wrap", rv, 32'd1);

        // R5 out-of-range select
        rd_ev(3, saved);
        wr(A_SEL, 6); wr(A_DAT, 32'h1234); wr(A_TYP, 32'h5);
        rd(A_SEL, rv); check("R5 select readback", rv, 32'd6);
        rd(A_DAT, rv); check("R5 data reads 0", rv, 32'h0);
        rd(A_TYP, rv); check("R5 type reads 0", rv, 32'h0);
        wr(A_SEL, 4); wr(A_DAT, 32'h55);
        rd(A_DAT, rv); check("R5 boundary select", rv, 32'h0);
        rd_ev(3, rv); check("R5 counter3 untouched", rv, saved);
        rd_ev(0, rv); check("R5 counter0 untouched", rv, 32'd1);
        rd(A_TYP, rv); check("R5 type0 untouched", rv, 32'd127);

        // R6 separate resets
        rd(A_CYC, saved);
        wr(A_CTRL, 32'h2);
        rd(A_DAT, rv); check("R6 event reset", rv, 32'h0);
        rd(A_CYC, rv); check("R6 cycle kept", rv, saved);
        wr(A_CTRL, 32'h4);
        rd(A_CYC, rv); check("R6 cycle reset", rv, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule